// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block lays a hardware cursor over one scanline of a 24-bit true-colour pixel stream. At the start of each line the host pulses `line_start` together with the cursor settings for that line: enable, size, horizontal position, hot-spot offset and the base address of the line's pattern bytes. The block then reads the line's pattern bytes through a simple request/acknowledge memory port and holds them in a small line store. Once the store is full, `line_ready` goes high. After that, every pixel whose beam position falls inside the cursor span is changed according to two 1-bit planes.

The planes are applied in a fixed order. A set bit in the mask plane first forces the pixel to black. A set bit in the invert plane then flips all 24 colour bits of whatever is left. A pixel with both bits set therefore comes out white. A pixel with only the invert bit set shows the inverse of the picture underneath. All other pixels pass through unchanged.

The output has a latency of one clock and accepts one pixel on every clock.

Top module: `hw_cursor_gen`

## Requirements
- R1: While reset is applied, `pix_out` is 0, `mem_req` is 0 and `line_ready` is 0.
- R2: After a `line_start` with `cur_en`=1, `mem_req` is held high and reads the pattern bytes in this order. For group g = 0, 1, 2, … the invert-plane byte is read at base+g, then the mask-plane byte at base+g+128. Addresses wrap modulo 2^ADDR_W. Address and request stay stable until `mem_ack`. `line_ready` rises on the clock after the last acknowledge, and `mem_req` is then low.
- R3: The cursor span is 32 pixels (4 groups, 8 reads) when `cur_large`=0, and 64 pixels (8 groups, 16 reads) when `cur_large`=1.
- R4: Cursor pixel p (p = 0 … span-1) sits at beam position `cur_x - cur_xoff + p`. It uses pattern group p/8 and bit 7-(p mod 8) of that group's bytes, so the MSB comes first.
- R5: A pixel whose mask-plane bit is 1 and whose invert-plane bit is 0 comes out as 0x000000.
- R6: A pixel whose invert-plane bit is 1 comes out as its input XOR 0xFFFFFF when its mask bit is 0, and as 0xFFFFFF when its mask bit is 1.
- R7: Beam positions below `cur_x` are never modified, even where they fall within the span that starts at `cur_x - cur_xoff`.
- R8: When the latched enable is 0, when `line_ready` is 0, or when the beam is outside the span, `pix_out` equals the `pix_in` of the previous clock.
- R9: A `line_start` during a fetch drops `line_ready` and restarts the read sequence from group 0, using the newly presented settings.
- R10: A new pixel is accepted and produced on every clock, with no stall.
- R11: The cursor settings are sampled only on the `line_start` clock. Later changes to them have no effect on the current line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_start | input | 1 | One-clock pulse that samples the cursor settings and starts the pattern fetch |
| cur_en | input | 1 | Cursor enable for the line |
| cur_large | input | 1 | 1 selects the 64-pixel cursor, 0 selects 32 |
| cur_x | input | X_W | Beam position of the first visible cursor pixel |
| cur_xoff | input | log2(LARGE_W) | Hot-spot offset subtracted from `cur_x` to give the span start |
| pat_addr | input | ADDR_W | Address of the line's first invert-plane byte |
| beam_x | input | X_W | Beam position of `pix_in` |
| pix_in | input | PIX_W | Underlying pixel |
| mem_req | output | 1 | Pattern read request |
| mem_addr | output | ADDR_W | Pattern read address |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid in the same clock |
| mem_rdata | input | 8 | Pattern byte |
| line_ready | output | 1 | The pattern store holds the full current line |
| pix_out | output | PIX_W | Pixel after the cursor overlay, one clock later |

## Verification
The bench goes after these corner cases:

- **Clipping.** A negative span start (hot-spot larger than `cur_x`) and the positions between the span start and `cur_x`. A design that ignored the clip would paint cursor bits to the left of the hot spot.
- **Plane order.** Pixels with both bits set must come out white. A design that applied the planes in the wrong order would output black there.
- **Restart mid-fetch.** A restart in the middle of a fetch must start over. A stale index would read from the wrong address or raise `line_ready` too early.
- **Early beam.** Lines where the beam reaches the span before the fetch completes must pass the pixels through until `line_ready` rises. A design without that gate would paint them from a half-filled store.
- **Settings changes.** The cursor settings are scrambled on every clock except the `line_start` clock. A design that read them live would move or resize the cursor mid-line.
- **Address wrap and span edge.** A base address near the top of the address space checks that reads wrap. A span that ends on the first visible pixel checks the final-bit edge.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  // Fetch sequencer state
  typedef enum logic [0:0] {
    FS_IDLE  = 1'b0,
    FS_FETCH = 1'b1
  } fetch_state_e;

  // Pixels per pattern byte
  localparam int unsigned PIX_PER_BYTE = 8;

endpackage

// File: rtl/hwc_rst_sync.sv
module hwc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/hwc_fetch.sv
module hwc_fetch
  import hwc_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int SMALL_W   = 32,
  parameter int LARGE_W   = 64,
  parameter int PLANE_GAP = 128,
  localparam int GROUPS_MAX = LARGE_W / PIX_PER_BYTE,
  localparam int GROUPS_MIN = SMALL_W / PIX_PER_BYTE,
  localparam int GRP_W      = $clog2(GROUPS_MAX),
  localparam int IDX_W      = GRP_W + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            line_start,
  input  logic                            start_en,
  input  logic                            cfg_large,
  input  logic [ADDR_W-1:0]               cfg_base,
  output logic                            mem_req,
  output logic [ADDR_W-1:0]               mem_addr,
  input  logic                            mem_ack,
  input  logic [7:0]                      mem_rdata,
  output logic                            line_ready,
  output logic [GROUPS_MAX-1:0][7:0]      inv_bytes,
  output logic [GROUPS_MAX-1:0][7:0]      mask_bytes
);

  localparam logic [IDX_W-1:0] LAST_LARGE = IDX_W'(2 * GROUPS_MAX - 1);
  localparam logic [IDX_W-1:0] LAST_SMALL = IDX_W'(2 * GROUPS_MIN - 1);

  fetch_state_e     state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ready_q, ready_d;
  logic [IDX_W-1:0] last_idx;
  logic [GRP_W-1:0] cur_grp;
  logic             cur_mask_plane;
  logic             take;

  assign last_idx       = cfg_large ? LAST_LARGE : LAST_SMALL;
  assign cur_grp        = idx_q[IDX_W-1:1];
  assign cur_mask_plane = idx_q[0];
  assign take           = (state_q == FS_FETCH) && mem_ack && !line_start;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ready_d = ready_q;
    if (line_start) begin
      ready_d = 1'b0;
      idx_d   = '0;
      state_d = start_en ? FS_FETCH : FS_IDLE;
    end else if (take) begin
      if (idx_q == last_idx) begin
        state_d = FS_IDLE;
        ready_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      idx_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ready_q <= ready_d;
    end
  end

  assign mem_req    = (state_q == FS_FETCH);
  assign mem_addr   = cfg_base + ADDR_W'(cur_grp)
                    + (cur_mask_plane ? ADDR_W'(PLANE_GAP) : '0);
  assign line_ready = ready_q;

  // Pattern line store: one byte per group per plane, each with its own enable
  for (genvar g = 0; g < GROUPS_MAX; g++) begin : g_store
    logic wr_inv, wr_mask;
    assign wr_inv  = take && !cur_mask_plane && (cur_grp == GRP_W'(g));
    assign wr_mask = take &&  cur_mask_plane && (cur_grp == GRP_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inv_bytes[g]  <= '0;
        mask_bytes[g] <= '0;
      end else begin
        if (wr_inv)  inv_bytes[g]  <= mem_rdata;
        if (wr_mask) mask_bytes[g] <= mem_rdata;
      end
    end
  end

  // R2: request and address held until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !line_start |=> mem_req && $stable(mem_addr));

  // R2: ready only rises on an acknowledged read
  p_ready_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_ready) |-> $past(mem_req && mem_ack));

  // R2: no reads once the line is held
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_ready |-> !mem_req);

  // R9: a start with enable always (re)opens the fetch
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && start_en |=> mem_req && !line_ready);

endmodule

// File: rtl/hwc_locate.sv
module hwc_locate
  import hwc_pkg::*;
#(
  parameter int X_W     = 12,
  parameter int SMALL_W = 32,
  parameter int LARGE_W = 64,
  localparam int GROUPS_MAX = LARGE_W / PIX_PER_BYTE,
  localparam int OFF_W      = $clog2(LARGE_W),
  localparam int SUB_W      = $clog2(PIX_PER_BYTE),
  localparam int SW         = X_W + 1
) (
  input  logic                       cfg_en,
  input  logic                       line_ready,
  input  logic                       cfg_large,
  input  logic [X_W-1:0]             cfg_x,
  input  logic [OFF_W-1:0]           cfg_xoff,
  input  logic [X_W-1:0]             beam_x,
  input  logic [GROUPS_MAX-1:0][7:0] inv_bytes,
  input  logic [GROUPS_MAX-1:0][7:0] mask_bytes,
  output logic                       hit,
  output logic                       bit_inv,
  output logic                       bit_mask
);

  logic [SW-1:0]         beam_shift;
  logic [SW-1:0]         span_end;
  logic [OFF_W-1:0]      rel;
  logic [OFF_W-SUB_W-1:0] grp;
  logic [SUB_W-1:0]      sub;
  logic [7:0]            inv_b, mask_b;

  // Position relative to the span start, kept non-negative by adding the
  // hot-spot offset to the beam instead of subtracting it from cur_x.
  assign beam_shift = {1'b0, beam_x} + SW'(cfg_xoff);
  assign span_end   = {1'b0, cfg_x} + (cfg_large ? SW'(LARGE_W) : SW'(SMALL_W));
  assign rel        = beam_shift[OFF_W-1:0] - cfg_x[OFF_W-1:0];
  assign grp        = rel[OFF_W-1:SUB_W];
  assign sub        = rel[SUB_W-1:0];

  assign hit = cfg_en && line_ready && (beam_x >= cfg_x) && (beam_shift < span_end);

  assign inv_b    = inv_bytes[grp];
  assign mask_b   = mask_bytes[grp];
  assign bit_inv  = inv_b[~sub];
  assign bit_mask = mask_b[~sub];

endmodule

// File: rtl/hwc_blend.sv
module hwc_blend #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             bit_inv,
  input  logic             bit_mask,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] pix_out
);

  logic [PIX_W-1:0] masked, pix_d;

  always_comb begin
    masked = (hit && bit_mask) ? '0 : pix_in;
    pix_d  = (hit && bit_inv) ? ~masked : masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= pix_d;
  end

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> pix_out == $past(pix_in));

  p_black_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit && bit_mask && !bit_inv |=> pix_out == '0);

  p_white_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit && bit_mask && bit_inv |=> pix_out == '1);

endmodule

// File: rtl/hw_cursor_gen.sv
module hw_cursor_gen
  import hwc_pkg::*;
#(
  parameter int PIX_W     = 24,
  parameter int X_W       = 12,
  parameter int ADDR_W    = 21,
  parameter int SMALL_W   = 32,
  parameter int LARGE_W   = 64,
  parameter int PLANE_GAP = 128,
  localparam int OFF_W      = $clog2(LARGE_W),
  localparam int GROUPS_MAX = LARGE_W / PIX_PER_BYTE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              cur_en,
  input  logic              cur_large,
  input  logic [X_W-1:0]    cur_x,
  input  logic [OFF_W-1:0]  cur_xoff,
  input  logic [ADDR_W-1:0] pat_addr,
  input  logic [X_W-1:0]    beam_x,
  input  logic [PIX_W-1:0]  pix_in,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              line_ready,
  output logic [PIX_W-1:0]  pix_out
);

  logic rst_sync_n;

  logic              cfg_en_q,    cfg_en_d;
  logic              cfg_large_q, cfg_large_d;
  logic [X_W-1:0]    cfg_x_q,     cfg_x_d;
  logic [OFF_W-1:0]  cfg_xoff_q,  cfg_xoff_d;
  logic [ADDR_W-1:0] cfg_base_q,  cfg_base_d;

  logic [GROUPS_MAX-1:0][7:0] inv_bytes, mask_bytes;
  logic hit, bit_inv, bit_mask;

  hwc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Per-line settings, captured only on line_start
  always_comb begin
    cfg_en_d    = cfg_en_q;
    cfg_large_d = cfg_large_q;
    cfg_x_d     = cfg_x_q;
    cfg_xoff_d  = cfg_xoff_q;
    cfg_base_d  = cfg_base_q;
    if (line_start) begin
      cfg_en_d    = cur_en;
      cfg_large_d = cur_large;
      cfg_x_d     = cur_x;
      cfg_xoff_d  = cur_xoff;
      cfg_base_d  = pat_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_en_q    <= 1'b0;
      cfg_large_q <= 1'b0;
      cfg_x_q     <= '0;
      cfg_xoff_q  <= '0;
      cfg_base_q  <= '0;
    end else begin
      cfg_en_q    <= cfg_en_d;
      cfg_large_q <= cfg_large_d;
      cfg_x_q     <= cfg_x_d;
      cfg_xoff_q  <= cfg_xoff_d;
      cfg_base_q  <= cfg_base_d;
    end
  end

  hwc_fetch #(
    .ADDR_W    (ADDR_W),
    .SMALL_W   (SMALL_W),
    .LARGE_W   (LARGE_W),
    .PLANE_GAP (PLANE_GAP)
  ) u_fetch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .line_start (line_start),
    .start_en   (cur_en),
    .cfg_large  (cfg_large_q),
    .cfg_base   (cfg_base_q),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .line_ready (line_ready),
    .inv_bytes  (inv_bytes),
    .mask_bytes (mask_bytes)
  );

  hwc_locate #(
    .X_W     (X_W),
    .SMALL_W (SMALL_W),
    .LARGE_W (LARGE_W)
  ) u_locate (
    .cfg_en     (cfg_en_q),
    .line_ready (line_ready),
    .cfg_large  (cfg_large_q),
    .cfg_x      (cfg_x_q),
    .cfg_xoff   (cfg_xoff_q),
    .beam_x     (beam_x),
    .inv_bytes  (inv_bytes),
    .mask_bytes (mask_bytes),
    .hit        (hit),
    .bit_inv    (bit_inv),
    .bit_mask   (bit_mask)
  );

  hwc_blend #(
    .PIX_W (PIX_W)
  ) u_blend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hit      (hit),
    .bit_inv  (bit_inv),
    .bit_mask (bit_mask),
    .pix_in   (pix_in),
    .pix_out  (pix_out)
  );

  // R11: settings registers only move on a line_start clock
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !line_start |=> $stable(cfg_x_q) && $stable(cfg_base_q) && $stable(cfg_en_q));

endmodule

// File: tb/hw_cursor_gen_tb.sv
`timescale 1ns/1ps
module hw_cursor_gen_tb;

  localparam int PIX_W    = 24;
  localparam int X_W      = 12;
  localparam int ADDR_W   = 21;
  localparam int LINE_LEN = 160;
  localparam int FAR_X    = 4000;

  logic              clk;
  logic              rst_n;
  logic              line_start;
  logic              cur_en;
  logic              cur_large;
  logic [X_W-1:0]    cur_x;
  logic [5:0]        cur_xoff;
  logic [ADDR_W-1:0] pat_addr;
  logic [X_W-1:0]    beam_x;
  logic [PIX_W-1:0]  pix_in;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ack;
  logic [7:0]        mem_rdata;
  logic              line_ready;
  logic [PIX_W-1:0]  pix_out;

  hw_cursor_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .cur_en     (cur_en),
    .cur_large  (cur_large),
    .cur_x      (cur_x),
    .cur_xoff   (cur_xoff),
    .pat_addr   (pat_addr),
    .beam_x     (beam_x),
    .pix_in     (pix_in),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .line_ready (line_ready),
    .pix_out    (pix_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  // Reference model state: settings as the design should hold them after the
  // coming clock edge, and the count of acknowledged reads.
  bit  m_en = 0, m_large = 0, m_restart = 0;
  int  m_x = 0, m_xoff = 0, m_base = 0, m_done = 0, m_wait = 0;
  logic [PIX_W-1:0] exp_pix = '0;
  string            exp_tag = "R8";
  int unsigned      lcg = 32'h1234_5678;

  function automatic int unsigned nxt(int unsigned s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  function automatic logic [7:0] mem_byte(int a);
    int unsigned u;
    u = a;
    return 8'((u * 73) ^ ((u >> 2) * 29) ^ 32'h5A);
  endfunction

  function automatic int wrap(int a);
    return a & ((1 << ADDR_W) - 1);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, expv, $time);
    end
  endtask

  // One clock: check outputs of the previous edge, then drive the next inputs.
  task automatic tick(bit ls, int beam, bit en, bit lg, int x, int xoff, int base);
    int need, size, start, p;
    bit rdy, a, b;
    logic [PIX_W-1:0] pv, v;
    @(negedge clk);
    need = m_large ? 16 : 8;
    rdy  = m_en && (m_done == need);
    // R10: one pixel compared on every clock; R8/R4..R7 tag from the model
    chk(pix_out == exp_pix, exp_tag, pix_out, exp_pix);
    chk(line_ready == rdy, m_restart ? "R9" : "R2", line_ready, rdy);
    chk(mem_req == (m_en && m_done < need), m_restart ? "R9" : "R2", mem_req, m_en && m_done < need);

    lcg = nxt(lcg);
    pv  = PIX_W'(lcg >> 5);
    size  = m_large ? 64 : 32;
    start = m_x - m_xoff;
    if (!rdy || beam < m_x || beam >= start + size) begin
      v = pv;
      exp_tag = (rdy && beam >= start && beam < m_x) ? "R7" : "R8";
    end else begin
      p = beam - start;
      a = mem_byte(wrap(m_base + p / 8))[7 - p % 8];
      b = mem_byte(wrap(m_base + p / 8 + 128))[7 - p % 8];
      v = pv;
      if (b) v = '0;
      if (a) v = v ^ 24'hFFFFFF;
      if (p >= 32)     exp_tag = "R3/R11";
      else if (a && b) exp_tag = "R6/R11";
      else if (b)      exp_tag = "R5/R11";
      else if (a)      exp_tag = "R6/R11";
      else             exp_tag = "R4/R11";
    end
    exp_pix = v;
    pix_in  = pv;
    beam_x  = X_W'(beam);
    mem_ack = 1'b0;

    if (ls) begin
      line_start = 1'b1;
      cur_en = en; cur_large = lg; cur_x = X_W'(x); cur_xoff = 6'(xoff);
      pat_addr = ADDR_W'(base);
      m_restart = m_en && (m_done < need);
      m_en = en; m_large = lg; m_x = x; m_xoff = xoff; m_base = base; m_done = 0;
      m_wait = 0;
    end else begin
      line_start = 1'b0;
      // R11: scrambled settings outside the start clock
      lcg = nxt(lcg);
      cur_en = lcg[20]; cur_large = lcg[21]; cur_x = X_W'(lcg >> 8);
      cur_xoff = 6'(lcg >> 3); pat_addr = ADDR_W'(lcg >> 9);
      if (mem_req && m_en && m_done < need) begin
        chk(mem_addr == ADDR_W'(wrap(m_base + m_done / 2 + (m_done % 2) * 128)),
            m_restart ? "R9" : "R2", mem_addr, wrap(m_base + m_done / 2 + (m_done % 2) * 128));
        if (m_wait == 0) begin
          mem_ack   = 1'b1;
          mem_rdata = mem_byte(int'(mem_addr));
          m_done++;
          lcg = nxt(lcg);
          m_wait = int'((lcg >> 16) % 3);
        end else begin
          m_wait--;
        end
      end
    end
  endtask

  task automatic run_line(bit en, bit lg, int x, int xoff, int base, int blank);
    tick(1, FAR_X, en, lg, x, xoff, base);
    repeat (blank) tick(0, FAR_X, 0, 0, 0, 0, 0);
    for (int b = 0; b < LINE_LEN; b++) tick(0, b, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10: run did not complete, actual=%0d cycles expected<200000", 200000);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; line_start = 1'b0; cur_en = 1'b0; cur_large = 1'b0;
    cur_x = '0; cur_xoff = '0; pat_addr = '0; beam_x = '0; pix_in = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) begin
      @(negedge clk);
      // R1: reset state
      chk(pix_out == '0, "R1", pix_out, 0);
      chk(mem_req == 1'b0 && line_ready == 1'b0, "R1", {mem_req, line_ready}, 0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_line(1, 0,  70,  0, 'h100,    60);   // small cursor, no hot-spot
    run_line(1, 1,  90,  5, 'h1_2340, 60);   // large cursor, hot-spot 5
    run_line(1, 1,  10, 20, 'h0_0800, 60);   // R7: start below zero, clipped
    run_line(0, 1,  70,  0, 'h100,    60);   // R8: disabled
    tick(1, FAR_X, 1, 0, 50, 0, 'h3000);     // R9: first start ...
    repeat (5) tick(0, FAR_X, 0, 0, 0, 0, 0);
    run_line(1, 1, 100, 63, 'h4000,   60);   // ... restarted mid-fetch
    run_line(1, 1,   5,  0, 'h0_5550,  0);   // R8: beam reaches span before ready
    run_line(1, 0, 128, 31, 'h6000,   60);   // R3: only last pixel of span visible
    run_line(1, 1, 100,  0, 'h1F_FFFA, 60);  // R2: address wrap
    run_line(1, 0,  40,  7, 'h7000,   60);
    tick(0, FAR_X, 0, 0, 0, 0, 0);
    finish_run();
  end

endmodule